// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Control

This block turns one binary-coded decimal digit into the seven segment drive lines (a to g) of a common-anode display. The drive is active low, so a 0 lights a segment. The whole path is combinational, so each output follows its inputs within the same cycle, with no register in between.

Three control inputs sit above the data path. A blanking input darkens the digit whatever the other inputs are. A lamp-test input lights every segment so that a dead segment can be seen. A ripple-blanking input blanks a zero digit and reports this on a ripple-blanking output. Several digits can be chained through the ripple pair to suppress leading or trailing zeros. The shared blanking-in / ripple-out pin of a classic decoder is split here into a separate input and output.

The segment polarity and the display for codes 10 to 15 are parameters. The defaults are active-low drive and a lone middle bar (a dash) for those codes.

Top module: `seg7_bcd_blanker`

## Requirements
- R1: With blanking, lamp test and ripple blanking all inactive (high), codes 0 to 9 light these segments. Bit 0 of the segment bus is segment a and bit 6 is segment g. Lit patterns as gfedcba: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R2: Segment outputs are active low: a lit segment is driven 0 and a dark segment is driven 1.
- R3: Codes 10 to 15 light segment g only. The segment bus then reads 0111111.
- R4: When the blanking input is high and the lamp-test input is low, all seven segment outputs are 0, whatever the digit and the ripple-blanking input are. The ripple output is then high.
- R5: When the blanking input is low, all seven segment outputs are 1, whatever the lamp test, the ripple input and the digit are. The ripple output is then high.
- R6: When blanking and lamp test are inactive, the ripple-blanking input is low and the digit is 0, all segments are dark (1111111) and the ripple output is low.
- R7: The ripple output is high in every case other than the one in R6.
- R8: A low ripple-blanking input has no effect on nonzero digits: codes 1 to 15 show their normal pattern.
- R9: In a two-digit chain, the tens digit's ripple input is tied low and its ripple output feeds the units digit's ripple input. In this chain a leading zero in the tens place is dark. The units digit is also dark only when both digits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_i | input | 4 | BCD digit, weights 1, 2, 4, 8 on bits 0 to 3 |
| lamp_test_n_i | input | 1 | Active-low lamp test, lights all segments |
| rbi_n_i | input | 1 | Active-low ripple-blanking input, blanks a zero digit |
| bi_n_i | input | 1 | Active-low blanking input, darkens the digit |
| seg_n_o | output | 7 | Active-low segment drive, bit 0 = a through bit 6 = g |
| rbo_n_o | output | 1 | Active-low ripple-blanking output, low when a zero was blanked |

## Verification
The checks are immediate assertions evaluated after the combinational outputs settle. They assume that every input holds a defined 0 or 1 value, and that the block is built with its default polarity and dash setting. The stimulus meets both conditions. Every input is driven from the first time step and changes only at a clock edge. The scoreboard compares the outputs half a period later, so no comparison sees a half-settled value.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

   // Display decision made by the blanking control
   typedef enum logic [1:0] {
      MODE_SHOW = 2'd0,
      MODE_ALL_ON = 2'd1,
      MODE_ALL_OFF = 2'd2
   } seg7_mode_e;

   localparam int SEG7_SEGS = 7;
   localparam int SEG7_BCD_BITS = 4;

   // Lit patterns (active high), bit 0 = a ... bit 6 = g
   localparam logic [6:0] GLYPH_DASH = 7'b1000000;
   localparam logic [6:0] GLYPH_NONE = 7'b0000000;

endpackage

// File: rtl/seg7_digit_map.sv
module seg7_digit_map #(
   parameter int BCD_W = 4,
   parameter int SEG_W = 7,
   parameter bit INVALID_BLANK = 1'b0
) (
   input logic [BCD_W-1:0] digit_i,
   output logic [SEG_W-1:0] lit_o,
   output logic is_zero_o
);
   import seg7_pkg::*;

   localparam int MAX_DIGIT = 9;

   generate
      if (BCD_W != SEG7_BCD_BITS) begin : g_bad_bcd
         $error("seg7_digit_map: BCD_W must be 4");
      end
      if (SEG_W != SEG7_SEGS) begin : g_bad_seg
         $error("seg7_digit_map: SEG_W must be 7");
      end
   endgenerate

   logic [SEG_W-1:0] decimal_lit;
   logic [SEG_W-1:0] non_digit_lit;
   logic is_decimal;

   assign is_decimal = (int'(digit_i) <= MAX_DIGIT);
   assign is_zero_o = (digit_i == '0);

   always_comb begin
      unique case (digit_i)
         4'd0: decimal_lit = 7'b0111111;
         4'd1: decimal_lit = 7'b0000110;
         4'd2: decimal_lit = 7'b1011011;
         4'd3: decimal_lit = 7'b1001111;
         4'd4: decimal_lit = 7'b1100110;
         4'd5: decimal_lit = 7'b1101101;
         4'd6: decimal_lit = 7'b1111101;
         4'd7: decimal_lit = 7'b0000111;
         4'd8: decimal_lit = 7'b1111111;
         4'd9: decimal_lit = 7'b1101111;
         default: decimal_lit = GLYPH_NONE;
      endcase
   end

   // Variant for codes above nine
   generate
      if (INVALID_BLANK) begin : g_non_digit_dark
         assign non_digit_lit = GLYPH_NONE;
      end else begin : g_non_digit_dash
         assign non_digit_lit = GLYPH_DASH;
      end
   endgenerate

   assign lit_o = is_decimal ? decimal_lit : non_digit_lit;

endmodule

// File: rtl/seg7_blank_ctrl.sv
module seg7_blank_ctrl (
   input logic is_zero_i,
   input logic lamp_test_n_i,
   input logic rbi_n_i,
   input logic bi_n_i,
   output seg7_pkg::seg7_mode_e mode_o,
   output logic rbo_n_o
);
   import seg7_pkg::*;

   logic ripple_hit;

   // Priority: blanking input, then lamp test, then ripple blanking
   assign ripple_hit = bi_n_i & lamp_test_n_i & ~rbi_n_i & is_zero_i;

   always_comb begin
      if (!bi_n_i) begin
         mode_o = MODE_ALL_OFF;
      end else if (!lamp_test_n_i) begin
         mode_o = MODE_ALL_ON;
      end else if (ripple_hit) begin
         mode_o = MODE_ALL_OFF;
      end else begin
         mode_o = MODE_SHOW;
      end
   end

   assign rbo_n_o = ~ripple_hit;

endmodule

// File: rtl/seg7_drive.sv
module seg7_drive #(
   parameter int SEG_W = 7,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input logic [SEG_W-1:0] lit_i,
   input seg7_pkg::seg7_mode_e mode_i,
   output logic [SEG_W-1:0] seg_o
);
   import seg7_pkg::*;

   logic [SEG_W-1:0] lit_final;

   always_comb begin
      unique case (mode_i)
         MODE_ALL_ON: lit_final = '1;
         MODE_ALL_OFF: lit_final = '0;
         default: lit_final = lit_i;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_common_anode
         assign seg_o = ~lit_final;
      end else begin : g_common_cathode
         assign seg_o = lit_final;
      end
   endgenerate

endmodule

// File: rtl/seg7_bcd_blanker.sv
module seg7_bcd_blanker #(
   parameter int BCD_W = 4,
   parameter int SEG_W = 7,
   parameter bit ACTIVE_LOW = 1'b1,
   parameter bit INVALID_BLANK = 1'b0
) (
   input logic [BCD_W-1:0] digit_i,
   input logic lamp_test_n_i,
   input logic rbi_n_i,
   input logic bi_n_i,
   output logic [SEG_W-1:0] seg_n_o,
   output logic rbo_n_o
);
   import seg7_pkg::*;

   logic [SEG_W-1:0] lit;
   logic is_zero;
   seg7_mode_e mode;

   seg7_digit_map #(
      .BCD_W(BCD_W),
      .SEG_W(SEG_W),
      .INVALID_BLANK(INVALID_BLANK)
   ) map_i (
      .digit_i(digit_i),
      .lit_o(lit),
      .is_zero_o(is_zero)
   );

   seg7_blank_ctrl ctrl_i (
      .is_zero_i(is_zero),
      .lamp_test_n_i(lamp_test_n_i),
      .rbi_n_i(rbi_n_i),
      .bi_n_i(bi_n_i),
      .mode_o(mode),
      .rbo_n_o(rbo_n_o)
   );

   seg7_drive #(
      .SEG_W(SEG_W),
      .ACTIVE_LOW(ACTIVE_LOW)
   ) drive_i (
      .lit_i(lit),
      .mode_i(mode),
      .seg_o(seg_n_o)
   );

endmodule

// File: rtl/seg7_bcd_blanker_chk.sv
module seg7_bcd_blanker_chk #(
   parameter int BCD_W = 4,
   parameter int SEG_W = 7,
   parameter bit ACTIVE_LOW = 1'b1,
   parameter bit INVALID_BLANK = 1'b0
) (
   input logic [BCD_W-1:0] digit_i,
   input logic lamp_test_n_i,
   input logic rbi_n_i,
   input logic bi_n_i,
   input logic [SEG_W-1:0] seg_n_o,
   input logic rbo_n_o
);
   localparam logic [SEG_W-1:0] DARK = ACTIVE_LOW ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
   localparam logic [SEG_W-1:0] BRIGHT = ~DARK;
   localparam logic [SEG_W-1:0] DASH_ON = ACTIVE_LOW ? 7'b0111111 : 7'b1000000;
   localparam logic [SEG_W-1:0] ZERO_ON = ACTIVE_LOW ? 7'b1000000 : 7'b0111111;

   logic normal_view;
   assign normal_view = bi_n_i && lamp_test_n_i;

   always_comb begin
      if (!bi_n_i) begin
         p_bi_dark_r5: assert (seg_n_o == DARK && rbo_n_o)
            else $error("blanking input did not darken the digit");
      end
      if (bi_n_i && !lamp_test_n_i) begin
         p_lamp_all_on_r4: assert (seg_n_o == BRIGHT && rbo_n_o)
            else $error("lamp test did not light every segment");
      end
      if (!rbo_n_o) begin
         p_rbo_only_zero_r6: assert (normal_view && !rbi_n_i && digit_i == '0 && seg_n_o == DARK)
            else $error("ripple output low outside a blanked zero");
      end
      if (normal_view && !rbi_n_i && digit_i == '0) begin
         p_rbo_asserted_r7: assert (!rbo_n_o)
            else $error("blanked zero did not pull the ripple output low");
      end
      if (normal_view && !INVALID_BLANK && int'(digit_i) > 9) begin
         p_dash_r3: assert (seg_n_o == DASH_ON)
            else $error("non-decimal code did not show a dash");
      end
      if (normal_view && rbi_n_i && digit_i == '0) begin
         p_zero_shown_r1: assert (seg_n_o == ZERO_ON)
            else $error("zero digit shown wrongly");
      end
      if (normal_view && digit_i != '0) begin
         p_nonzero_not_dark_r8: assert (seg_n_o != DARK && rbo_n_o)
            else $error("nonzero digit was blanked");
      end
   end

endmodule

bind seg7_bcd_blanker seg7_bcd_blanker_chk #(
   .BCD_W(BCD_W),
   .SEG_W(SEG_W),
   .ACTIVE_LOW(ACTIVE_LOW),
   .INVALID_BLANK(INVALID_BLANK)
) chk_i (
   .digit_i(digit_i),
   .lamp_test_n_i(lamp_test_n_i),
   .rbi_n_i(rbi_n_i),
   .bi_n_i(bi_n_i),
   .seg_n_o(seg_n_o),
   .rbo_n_o(rbo_n_o)
);

// File: tb/seg7_bcd_blanker_tb_top.sv
`timescale 1ns/1ps
module seg7_bcd_blanker_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // single-digit DUT
   logic [3:0] digit = 4'd0;
   logic lt_n = 1'b1;
   logic rbi_n = 1'b1;
   logic bi_n = 1'b1;
   logic [6:0] seg_n;
   logic rbo_n;

   seg7_bcd_blanker dut_i (
      .digit_i(digit), .lamp_test_n_i(lt_n), .rbi_n_i(rbi_n), .bi_n_i(bi_n),
      .seg_n_o(seg_n), .rbo_n_o(rbo_n)
   );

   // two-digit chain for R9
   logic [3:0] tens_d = 4'd0;
   logic [3:0] units_d = 4'd0;
   logic [6:0] tens_seg;
   logic [6:0] units_seg;
   logic tens_rbo;
   logic units_rbo;

   seg7_bcd_blanker tens_i (
      .digit_i(tens_d), .lamp_test_n_i(1'b1), .rbi_n_i(1'b0), .bi_n_i(1'b1),
      .seg_n_o(tens_seg), .rbo_n_o(tens_rbo)
   );
   seg7_bcd_blanker units_i (
      .digit_i(units_d), .lamp_test_n_i(1'b1), .rbi_n_i(tens_rbo), .bi_n_i(1'b1),
      .seg_n_o(units_seg), .rbo_n_o(units_rbo)
   );

   typedef struct {
      bit chain;
      logic [6:0] seg_a;
      logic rbo_a;
      logic [6:0] seg_b;
      string tag;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // lit patterns from R1 / R3 (gfedcba), inverted for active-low drive (R2)
   function automatic logic [6:0] glyph(input logic [3:0] d);
      case (d)
         4'd0: return 7'b0111111;
         4'd1: return 7'b0000110;
         4'd2: return 7'b1011011;
         4'd3: return 7'b1001111;
         4'd4: return 7'b1100110;
         4'd5: return 7'b1101101;
         4'd6: return 7'b1111101;
         4'd7: return 7'b0000111;
         4'd8: return 7'b1111111;
         4'd9: return 7'b1101111;
         default: return 7'b1000000;
      endcase
   endfunction

   function automatic logic [7:0] expect_out(input logic [3:0] d, input logic lt,
                                             input logic rbi, input logic bi);
      if (!bi) return {1'b1, 7'b1111111};
      if (!lt) return {1'b1, 7'b0000000};
      if (!rbi && d == 4'd0) return {1'b0, 7'b1111111};
      return {1'b1, ~glyph(d)};
   endfunction

   task automatic drive_one(input logic [3:0] d, input logic lt, input logic rbi,
                            input logic bi, input string tag);
      item_t it;
      logic [7:0] e;
      @(posedge clk);
      digit = d; lt_n = lt; rbi_n = rbi; bi_n = bi;
      e = expect_out(d, lt, rbi, bi);
      it.chain = 1'b0; it.seg_a = e[6:0]; it.rbo_a = e[7]; it.seg_b = '0; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic drive_chain(input logic [3:0] t, input logic [3:0] u, input string tag);
      item_t it;
      logic [7:0] et;
      logic [7:0] eu;
      @(posedge clk);
      tens_d = t; units_d = u;
      et = expect_out(t, 1'b1, 1'b0, 1'b1);
      eu = expect_out(u, 1'b1, et[7], 1'b1);
      it.chain = 1'b1; it.seg_a = et[6:0]; it.rbo_a = 1'b0; it.seg_b = eu[6:0]; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compare half a period after the inputs change
   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         if (!it.chain) begin
            checks = checks + 2;
            if (seg_n !== it.seg_a) begin
               errors++;
               $display("FAIL %s seg_n actual %b expected %b", it.tag, seg_n, it.seg_a);
            end
            if (rbo_n !== it.rbo_a) begin
               errors++;
               $display("FAIL %s rbo_n actual %b expected %b", it.tag, rbo_n, it.rbo_a);
            end
         end else begin
            checks = checks + 2;
            if (tens_seg !== it.seg_a) begin
               errors++;
               $display("FAIL %s tens seg actual %b expected %b", it.tag, tens_seg, it.seg_a);
            end
            if (units_seg !== it.seg_b) begin
               errors++;
               $display("FAIL %s units seg actual %b expected %b", it.tag, units_seg, it.seg_b);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: idle controls show a zero (R1)
      drive_one(4'd0, 1'b1, 1'b1, 1'b1, "R1 idle");
      // R1 R2: every decimal digit
      for (int d = 0; d < 10; d++) drive_one(4'(d), 1'b1, 1'b1, 1'b1, "R1 R2 digit");
      // R3: non-decimal codes
      for (int d = 10; d < 16; d++) drive_one(4'(d), 1'b1, 1'b1, 1'b1, "R3 dash");
      // R4: lamp test over data and ripple blanking
      drive_one(4'd0, 1'b0, 1'b0, 1'b1, "R4 lamp over ripple");
      drive_one(4'd7, 1'b0, 1'b1, 1'b1, "R4 lamp digit7");
      drive_one(4'd12, 1'b0, 1'b1, 1'b1, "R4 lamp code12");
      // R5: blanking over everything
      drive_one(4'd8, 1'b0, 1'b1, 1'b0, "R5 blank over lamp");
      drive_one(4'd0, 1'b1, 1'b0, 1'b0, "R5 blank over ripple");
      drive_one(4'd3, 1'b1, 1'b1, 1'b0, "R5 blank digit3");
      // R6: ripple-blanked zero
      drive_one(4'd0, 1'b1, 1'b0, 1'b1, "R6 ripple zero");
      // R7: ripple output high when zero shown
      drive_one(4'd0, 1'b1, 1'b1, 1'b1, "R7 rbo high zero shown");
      // R8: ripple input ignored for nonzero codes
      for (int d = 1; d < 16; d++) drive_one(4'(d), 1'b1, 1'b0, 1'b1, "R8 rbi nonzero");
      // R9: two-digit leading-zero chain
      drive_chain(4'd0, 4'd5, "R9 chain 05");
      drive_chain(4'd0, 4'd0, "R9 chain 00");
      drive_chain(4'd1, 4'd0, "R9 chain 10");
      drive_chain(4'd4, 4'd7, "R9 chain 47");
      drive_chain(4'd0, 4'd9, "R9 chain 09");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule